// File: doc/BRIEF.md
# Dual-Channel High/Low-Count PWM Generator

This block produces two independent pulse-width-modulated outputs, programmed through a small word-addressed register port. Each channel picks one of four incoming clock strobes, passes it through a clock gate and a 7-bit divider, and uses the resulting ticks to drive its output high for a programmed number of ticks and then low for another programmed number. The cycle repeats as long as the channel is enabled.

The waveform is described by two 16-bit counts packed into one word per channel: the high-time count and the low-time count. There is no period register and no compare register. Both channels share one control word. That word holds each channel's run bit, source select, divider value and clock gate. Software works out the counts and any inversion. The block only plays back what it is given. New counts written while a channel runs are held back until the current period has finished, so every phase completes at its programmed length.

Top module: `dual_pwm_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all three registers read zero and both outputs are low.
- R2: Offset 0x0 holds channel 0's counts and offset 0x4 holds channel 1's counts. The high-time count sits in bits 31:16 and the low-time count in bits 15:0. All 32 bits read back exactly as written.
- R3: Offset 0x8 is the shared control word. Only bits 23:4 and 1:0 are stored, and every other bit reads zero. A write to any other offset is ignored, and a read from any other offset returns zero.
- R4: While a channel's run bit is clear, its output is low and its divider and phase position are held at zero. When the run bit is set, the output begins with a high phase in the next cycle.
- R5: Channel 0 takes its tick source from control bits 5:4, its divider from bits 14:8 and its gate from bit 15. Channel 1 uses bits 7:6, 22:16 and 23 for the same purposes. A tick occurs on every (divider+1)-th pulse of the selected strobe.
- R6: A running channel holds its output high for the high-time count of ticks, then low for the low-time count of ticks, and repeats.
- R7: A high-time count of zero with a nonzero low-time count keeps the output low. A low-time count of zero with a nonzero high-time count keeps the output high.
- R8: When both counts are zero, the output stays low.
- R9: Counts written while a channel runs take effect only when the current period ends, at the end of the low phase.
- R10: While a channel's gate bit is clear, no ticks occur and the output holds its level.
- R11: The two channels run independently of each other, each with its own source, divider and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_strobe | input | 4 | One-cycle pulses from the four selectable clock sources |
| pwm_out | output | 2 | Channel outputs; bit 0 is channel 0 |

## Verification
Assertions check these properties on every cycle:
- the phase position of a running channel stays inside its period;
- a zero high-time count forces the output low;
- stored counts stay constant in the middle of a period;
- the divider and the phase position do not move while the source strobe or the clock gate is idle;
- unused control bits never hold a one.

Some behaviours can only be shown by the bench's scenarios, which compare the outputs against a behavioural reference on every clock. These are:
- exact high and low durations under different sources and divider values;
- the first high phase after enable;
- the deferred update of counts written in the middle of a period;
- the constant-level cases;
- the register map and its masking.

// File: rtl/pwm_gen_pkg.sv
// Package: shared constants and the per-channel configuration type.
// Assumes a 32-bit register word and four selectable tick sources.
package pwm_gen_pkg;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int SEL_W   = 2;
    localparam int NSRC    = 1 << SEL_W;
    localparam int NCH     = 2;
    localparam int POS_W   = CNT_W + 1;
    localparam logic [31:0] CTRL_KEEP = 32'h00FF_FFF3;

    typedef struct packed {
        logic             run;
        logic             gate;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_gen_regs.sv
// Register file: two count words and one shared control word.
// Assumes single-cycle writes and a combinational read path.
module pwm_gen_regs
    import pwm_gen_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output chan_cfg_t [NCH-1:0]   cfg
);
    localparam logic [ADDR_W-1:0] OFF_C0   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_C1   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8);

    logic [31:0] cnt_q [NCH];
    logic [31:0] ctrl_q;

    // Store register writes; unused control bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
            ctrl_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_C0:   cnt_q[0] <= wdata;
                OFF_C1:   cnt_q[1] <= wdata;
                OFF_CTRL: ctrl_q   <= wdata & CTRL_KEEP;
                default:  ;
            endcase
        end
    end

    // Return the addressed word, or zero for an unmapped offset.
    always_comb begin
        case (addr)
            OFF_C0:   rdata = cnt_q[0];
            OFF_C1:   rdata = cnt_q[1];
            OFF_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        // Slice each channel's fields out of the shared control word.
        always_comb begin
            cfg[g].run  = ctrl_q[g];
            cfg[g].sel  = ctrl_q[4 + SEL_W*g +: SEL_W];
            cfg[g].div  = ctrl_q[8 + 8*g +: DIV_W];
            cfg[g].gate = ctrl_q[15 + 8*g];
            cfg[g].hi   = cnt_q[g][31:16];
            cfg[g].lo   = cnt_q[g][15:0];
        end
    end

    assert_ctrl_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_KEEP) == 32'h0);
endmodule

// File: rtl/pwm_gen_prescale.sv
// Source select, clock gate and divider for one channel.
// Assumes strobes are single-cycle pulses that are synchronous to clk.
module pwm_gen_prescale
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    input  logic [NSRC-1:0]  strobe,
    output logic             tick
);
    logic [DIV_W-1:0] pre_q;
    logic             raw;

    // Selected source pulse, passed only when the gate bit is set.
    always_comb raw = gate & strobe[sel];
    // A tick fires on the pulse that completes a divider round.
    always_comb tick = raw & (pre_q >= div);

    // Count source pulses; restart after div+1 pulses or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else if (raw)       pre_q <= (pre_q >= div) ? '0 : pre_q + 1'b1;
    end

    assert_divider_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(raw)) |-> $stable(pre_q));
endmodule

// File: rtl/pwm_gen_phase.sv
// High/low phase sequencer for one channel.
// Assumes tick is a one-cycle enable. Counts reload only at a period boundary.
module pwm_gen_phase
    import pwm_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             out
);
    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] hi_q, lo_q;
    logic [POS_W-1:0] total;

    // Period length in ticks, taken from the counts held for this period.
    always_comb total = {1'b0, hi_q} + {1'b0, lo_q};

    // Advance the position in the period; reload counts at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (!run || total == '0) begin
            pos_q <= '0;
            hi_q  <= hi;
            lo_q  <= lo;
        end else if (tick) begin
            if (pos_q == total - 1'b1) begin
                pos_q <= '0;
                hi_q  <= hi;
                lo_q  <= lo;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // High during the first hi_q ticks of the period.
    always_comb out = run & (pos_q < {1'b0, hi_q});

    assert_pos_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && total != '0) |-> (pos_q < total));
    assert_zero_high_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_q == '0) |-> !out);
    assert_counts_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && pos_q != '0) |-> ($stable(hi_q) && $stable(lo_q)));
    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(tick)) |-> $stable(pos_q));
endmodule

// File: rtl/dual_pwm_gen.sv
// Top level: register file and two channels, each a divider and a phase sequencer.
// Assumes one clock domain. Source clocks arrive as strobes.
module dual_pwm_gen
    import pwm_gen_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NSRC-1:0]   src_strobe,
    output logic [NCH-1:0]    pwm_out
);
    chan_cfg_t [NCH-1:0] cfg;
    logic      [NCH-1:0] tick;

    pwm_gen_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_gen_prescale u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (cfg[c].run),
            .gate   (cfg[c].gate),
            .sel    (cfg[c].sel),
            .div    (cfg[c].div),
            .strobe (src_strobe),
            .tick   (tick[c])
        );
        pwm_gen_phase u_ph (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (cfg[c].run),
            .tick  (tick[c]),
            .hi    (cfg[c].hi),
            .lo    (cfg[c].lo),
            .out   (pwm_out[c])
        );
    end
endmodule

// File: tb/tb_dual_pwm_gen.sv
`timescale 1ns/1ps
module tb_dual_pwm_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_strobe = 0;
    logic [1:0]  pwm_out;

    int checks = 0, failures = 0;
    string cur_req = "R1";
    bit cmp_on = 0;
    int cyc = 0;

    // reference model state
    longint m_cnt[2], m_ctrl;
    int m_pre[2], m_pos[2], m_hi[2], m_lo[2];

    dual_pwm_gen #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_strobe(src_strobe), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    // strobe sources: every cycle, every 2nd, every 3rd, every 5th
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 src_strobe <= {((cyc % 5) == 0), ((cyc % 3) == 0), ((cyc % 2) == 0), 1'b1};
    end

    // reference model, updated from the values present before each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_pre[c] = 0; m_pos[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
            end
            m_ctrl = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                bit run, gate, raw, tk;
                int sel, dv;
                run  = m_ctrl[c];
                gate = m_ctrl[15 + 8*c];
                sel  = int'((m_ctrl >> (4 + 2*c)) & 3);
                dv   = int'((m_ctrl >> (8 + 8*c)) & 127);
                raw  = gate && src_strobe[sel];
                tk   = raw && (m_pre[c] >= dv);
                if (!run) begin
                    m_pre[c] = 0; m_pos[c] = 0;
                    m_hi[c] = int'(m_cnt[c] >> 16); m_lo[c] = int'(m_cnt[c] & 'hFFFF);
                end else begin
                    if (raw) m_pre[c] = (m_pre[c] >= dv) ? 0 : m_pre[c] + 1;
                    if (m_hi[c] + m_lo[c] == 0) begin
                        m_pos[c] = 0;
                        m_hi[c] = int'(m_cnt[c] >> 16); m_lo[c] = int'(m_cnt[c] & 'hFFFF);
                    end else if (tk) begin
                        if (m_pos[c] == m_hi[c] + m_lo[c] - 1) begin
                            m_pos[c] = 0;
                            m_hi[c] = int'(m_cnt[c] >> 16); m_lo[c] = int'(m_cnt[c] & 'hFFFF);
                        end else m_pos[c]++;
                    end
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: m_cnt[0] = bus_wdata;
                    4'h4: m_cnt[1] = bus_wdata;
                    4'h8: m_ctrl = bus_wdata & 32'h00FF_FFF3;
                    default: ;
                endcase
            end
        end
    end

    // compare outputs with the model on every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            longint er;
            case (bus_addr)
                4'h0: er = m_cnt[0];
                4'h4: er = m_cnt[1];
                4'h8: er = m_ctrl;
                default: er = 0;
            endcase
            chk(bus_rdata == er[31:0], {cur_req, " rdata"}, bus_rdata, er);
            for (int c = 0; c < 2; c++) begin
                bit e;
                e = m_ctrl[c] && (m_pos[c] < m_hi[c]);
                chk(pwm_out[c] == e, {cur_req, " pwm_out"}, pwm_out[c], e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0; bus_addr = 4'h8;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1 bus_addr = a;
        @(negedge clk); chk(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic count_high(input int ch, input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); h += pwm_out[ch];
        end
    endtask

    initial begin
        #(5.0 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int h;
        logic lvl;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        cmp_on = 1;
        // R1 reset state
        cur_req = "R1";
        rd(4'h0, 0, "R1 cnt0"); rd(4'h4, 0, "R1 cnt1"); rd(4'h8, 0, "R1 ctrl");
        @(negedge clk); chk(pwm_out == 2'b00, "R1 outputs", pwm_out, 0);
        // R2 count readback
        cur_req = "R2";
        wr(4'h0, 32'hA5C3_1E77); rd(4'h0, 32'hA5C3_1E77, "R2 cnt0");
        wr(4'h4, 32'h0102_F0E0); rd(4'h4, 32'h0102_F0E0, "R2 cnt1");
        // R3 mask and unmapped offsets
        cur_req = "R3";
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, 32'h00FF_FFF3, "R3 ctrl mask");
        wr(4'h8, 32'h0);
        wr(4'hC, 32'hDEAD_BEEF); rd(4'hC, 0, "R3 unmapped read");
        rd(4'h0, 32'hA5C3_1E77, "R3 unmapped write ignored");
        // R6 basic waveform: hi 3, lo 2, every cycle a tick
        cur_req = "R6";
        wr(4'h0, 32'h0003_0002);
        wr(4'h8, 32'h0000_8001);
        @(negedge clk); chk(pwm_out[0] == 1, "R4 starts high", pwm_out[0], 1);
        count_high(0, 25, h); chk(h == 15, "R6 duty 3/5", h, 15);
        // R5 source 1 (every 2nd cycle), divider 2: tick every 6 cycles
        cur_req = "R5";
        wr(4'h8, 32'h0);
        wr(4'h8, 32'h0000_8211);
        count_high(0, 60, h); chk(h == 36, "R5 divided duty", h, 36);
        // R10 gate off holds level
        cur_req = "R10";
        wr(4'h8, 32'h0000_0211);
        @(negedge clk); lvl = pwm_out[0];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); chk(pwm_out[0] == lvl, "R10 hold", pwm_out[0], lvl);
        end
        // R4 disable drives low
        cur_req = "R4";
        wr(4'h8, 32'h0);
        @(negedge clk); chk(pwm_out[0] == 0, "R4 disabled low", pwm_out[0], 0);
        // R7 constant levels
        cur_req = "R7";
        wr(4'h0, 32'h0000_0004); wr(4'h8, 32'h0000_8001);
        count_high(0, 30, h); chk(h == 0, "R7 zero high", h, 0);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0004_0000); wr(4'h8, 32'h0000_8001);
        count_high(0, 30, h); chk(h == 30, "R7 zero low", h, 30);
        // R8 both zero
        cur_req = "R8";
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0); wr(4'h8, 32'h0000_8001);
        count_high(0, 20, h); chk(h == 0, "R8 both zero", h, 0);
        // R9 mid-period update
        cur_req = "R9";
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0006_0006); wr(4'h8, 32'h0000_8001);
        repeat (3) @(posedge clk);
        wr(4'h0, 32'h0001_0001);
        @(negedge clk); chk(pwm_out[0] == 1, "R9 high phase kept", pwm_out[0], 1);
        repeat (40) @(posedge clk);
        // R11 both channels with different settings
        cur_req = "R11";
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0002_0005);
        wr(4'h4, 32'h0004_0003);
        wr(4'h8, 32'h0081_80E3);
        repeat (150) @(posedge clk);
        wr(4'h4, 32'h0001_0002);
        repeat (100) @(posedge clk);
        @(negedge clk);
        cmp_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule